// File: doc/BRIEF.md
# Variable-Block-Size SAD Tree

This block scores one motion-search candidate for a 16x16 macroblock in a single clock. The caller presents the current macroblock and the reference block at one candidate offset, both as 256 pixels, with the candidate's motion vector and a valid strobe. The block builds sixteen 4x4 difference sums. It adds them into the costs of all 41 partitions that variable-block-size motion search uses. Each cost is compared with the best cost stored for that partition, and the stored cost and motion vector are replaced when the new candidate is strictly better.

Two reductions keep the arithmetic small. Each pixel is cut to its 5 most significant bits before the absolute difference is taken. Only the pixels on one colour of a checkerboard take part, which is half of every block. No partial sums are kept between cycles. A start pulse at the head of each macroblock search resets the 41 stored minima, and the search controller then streams candidates at up to one per clock.

Top module: `vbs_sad_tree`

## Requirements
- R1: While `rst_n` is low, every stored cost reads 4095 (all ones in the 12-bit cost field) and every stored motion-vector component reads 0.
- R2: Pixel (row y, column x) occupies bits `[(y*16+x)*8 +: 8]` of each pixel bus. Only bits 7:3 of each pixel enter the difference. Only positions with y+x even contribute. Changes confined to bits 2:0 or to odd-parity positions leave every cost unchanged.
- R3: Cost slots 0 to 15 are the 4x4 blocks, slot = 4*row + column over the 4x4 grid of blocks.
- R4: Slots 16 to 23 are the 8-wide by 4-tall blocks (16 + 2*row + column). Slots 24 to 31 are the 4-wide by 8-tall blocks (24 + 4*row + column).
- R5: Slots 32 to 35 are the 8x8 blocks (32 + 2*row + column). Slots 36 and 37 are the upper and lower 16x8 halves. Slots 38 and 39 are the left and right 8x16 halves. Slot 40 is the whole 16x16 block.
- R6: A slot takes the candidate's cost and motion vector only if the cost is strictly less than the stored cost. On a tie the earlier candidate is kept.
- R7: Each of the 41 slots is updated on its own, so different slots may end up holding different motion vectors after the same search.
- R8: `mb_start` sets all stored costs to 4095 and all vectors to 0. If `cand_valid` is high in the same cycle, that candidate is compared against the cleared values, so it is stored in every slot.
- R9: A candidate presented with `cand_valid` high is reflected at the outputs after the clock edge that samples it. With `cand_valid` and `mb_start` low, the outputs hold, whatever is on the pixel and vector inputs.
- R10: Costs are 12 bits wide. The largest possible 16x16 cost is 3968 (128 pixels times 31), which is below the cleared value of 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mb_start | input | 1 | Resets the stored minima at the start of a macroblock search |
| cand_valid | input | 1 | The pixel buses and vector carry a candidate to be scored |
| cur_pix | input | 2048 | Current macroblock, 256 pixels of 8 bits, in raster order |
| ref_pix | input | 2048 | Reference block at the candidate offset, in the same layout |
| cand_mv_x | input | 8 | Horizontal component of the candidate vector (two's complement) |
| cand_mv_y | input | 8 | Vertical component of the candidate vector (two's complement) |
| best_cost | output | 492 | 41 stored minimum costs, 12 bits each, slot n at bits [n*12 +: 12] |
| best_mv_x | output | 328 | 41 stored horizontal vectors, slot n at bits [n*8 +: 8] |
| best_mv_y | output | 328 | 41 stored vertical vectors, slot n at bits [n*8 +: 8] |

## Verification
The checker assumes that `mb_start` precedes the first candidate of each search, so that the stored minima never rise except through that pulse. It also assumes that every stored cost is either the cleared value or a sum that fits under the 16x16 bound. Neither the pixel buses nor the vectors are constrained, so the stimulus uses random pixels and vectors over the full 8-bit range. Each macroblock search in the stimulus opens with a start pulse. Around the start pulses it places crafted cases: ties, idle cycles with changing data, low-bit-only and odd-position-only changes, and the maximum-difference block.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
    // Partition slot layout for a 4x4 grid of elementary blocks
    localparam int N4X4     = 16;
    localparam int N8X4     = 8;
    localparam int N4X8     = 8;
    localparam int N8X8     = 4;
    localparam int N16X8    = 2;
    localparam int N8X16    = 2;
    localparam int N16X16   = 1;
    localparam int NUM_PART = N4X4 + N8X4 + N4X8 + N8X8 + N16X8 + N8X16 + N16X16;

    function automatic int cost_width(input int mb_dim, input int trunc_w);
        // Room for the largest sum plus one spare code for the cleared value
        return $clog2(((mb_dim * mb_dim) / 2) * ((2 ** trunc_w) - 1) + 2);
    endfunction
endpackage

// File: rtl/vbs_blk_sad.sv
module vbs_blk_sad #(
    parameter int PIX_W   = 8,
    parameter int TRUNC_W = 5,
    parameter int BLK     = 4,
    parameter int COST_W  = 12,
    parameter int PARITY  = 0
) (
    input  logic [BLK*BLK*PIX_W-1:0] cur_blk,
    input  logic [BLK*BLK*PIX_W-1:0] ref_blk,
    output logic [COST_W-1:0]        sad
);
    function automatic logic [COST_W-1:0] blk_sum(
        input logic [BLK*BLK*PIX_W-1:0] c,
        input logic [BLK*BLK*PIX_W-1:0] r
    );
        logic [COST_W-1:0]  acc;
        logic [TRUNC_W-1:0] a;
        logic [TRUNC_W-1:0] b;
        logic [TRUNC_W-1:0] d;
        acc = '0;
        for (int y = 0; y < BLK; y++) begin
            for (int x = 0; x < BLK; x++) begin
                if (((y + x + PARITY) % 2) == 0) begin
                    a   = c[(y*BLK+x)*PIX_W + PIX_W - 1 -: TRUNC_W];
                    b   = r[(y*BLK+x)*PIX_W + PIX_W - 1 -: TRUNC_W];
                    d   = (a > b) ? (a - b) : (b - a);
                    acc = acc + COST_W'(d);
                end
            end
        end
        return acc;
    endfunction

    always_comb begin
        sad = blk_sum(cur_blk, ref_blk);
    end
endmodule

// File: rtl/vbs_merge.sv
module vbs_merge
    import vbs_pkg::*;
#(
    parameter int COST_W = 12
) (
    input  logic [N4X4-1:0][COST_W-1:0]     s4,
    output logic [NUM_PART-1:0][COST_W-1:0] part
);
    localparam int G = 4;

    logic [N8X4-1:0][COST_W-1:0]   p84;
    logic [N4X8-1:0][COST_W-1:0]   p48;
    logic [N8X8-1:0][COST_W-1:0]   p88;
    logic [N16X8-1:0][COST_W-1:0]  p168;
    logic [N8X16-1:0][COST_W-1:0]  p816;
    logic [COST_W-1:0]             p1616;

    for (genvar r = 0; r < G; r++) begin : g_wide
        for (genvar c = 0; c < G/2; c++) begin : g_col
            assign p84[r*2+c] = s4[r*G+2*c] + s4[r*G+2*c+1];
        end
    end

    for (genvar r = 0; r < G/2; r++) begin : g_tall
        for (genvar c = 0; c < G; c++) begin : g_col
            assign p48[r*G+c] = s4[(2*r)*G+c] + s4[(2*r+1)*G+c];
        end
    end

    for (genvar r = 0; r < 2; r++) begin : g_quad
        for (genvar c = 0; c < 2; c++) begin : g_col
            assign p88[r*2+c] = p84[(2*r)*2+c] + p84[(2*r+1)*2+c];
        end
        assign p168[r] = p88[2*r] + p88[2*r+1];
        assign p816[r] = p88[r] + p88[r+2];
    end

    assign p1616 = p168[0] + p168[1];

    assign part = {p1616, p816, p168, p88, p48, p84, s4};
endmodule

// File: rtl/vbs_best_bank.sv
module vbs_best_bank #(
    parameter int NP     = 41,
    parameter int COST_W = 12,
    parameter int MV_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       mb_start,
    input  logic                       cand_valid,
    input  logic [NP-1:0][COST_W-1:0]  cand_cost,
    input  logic [MV_W-1:0]            cand_mv_x,
    input  logic [MV_W-1:0]            cand_mv_y,
    output logic [NP-1:0][COST_W-1:0]  best_cost,
    output logic [NP-1:0][MV_W-1:0]    best_mv_x,
    output logic [NP-1:0][MV_W-1:0]    best_mv_y
);
    typedef struct packed {
        logic [NP-1:0][COST_W-1:0] cost;
        logic [NP-1:0][MV_W-1:0]   mvx;
        logic [NP-1:0][MV_W-1:0]   mvy;
    } bank_t;

    localparam bank_t BANK_INIT = '{cost: '1, mvx: '0, mvy: '0};

    bank_t st_d;
    bank_t st_q;

    always_comb begin
        st_d = st_q;
        if (mb_start) begin
            st_d = BANK_INIT;
        end
        if (cand_valid) begin
            for (int i = 0; i < NP; i++) begin
                if (cand_cost[i] < st_d.cost[i]) begin
                    st_d.cost[i] = cand_cost[i];
                    st_d.mvx[i]  = cand_mv_x;
                    st_d.mvy[i]  = cand_mv_y;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= BANK_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign best_cost = st_q.cost;
    assign best_mv_x = st_q.mvx;
    assign best_mv_y = st_q.mvy;
endmodule

// File: rtl/vbs_sad_tree.sv
module vbs_sad_tree
    import vbs_pkg::*;
#(
    parameter int  PIX_W   = 8,
    parameter int  TRUNC_W = 5,
    parameter int  MB_DIM  = 16,
    parameter int  BLK     = 4,
    parameter int  MV_W    = 8,
    localparam int NPIX    = MB_DIM * MB_DIM,
    localparam int COST_W  = cost_width(MB_DIM, TRUNC_W)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         mb_start,
    input  logic                         cand_valid,
    input  logic [NPIX*PIX_W-1:0]        cur_pix,
    input  logic [NPIX*PIX_W-1:0]        ref_pix,
    input  logic [MV_W-1:0]              cand_mv_x,
    input  logic [MV_W-1:0]              cand_mv_y,
    output logic [NUM_PART*COST_W-1:0]   best_cost,
    output logic [NUM_PART*MV_W-1:0]     best_mv_x,
    output logic [NUM_PART*MV_W-1:0]     best_mv_y
);
    localparam int G     = MB_DIM / BLK;
    localparam int BLK_B = BLK * BLK * PIX_W;

    logic [N4X4-1:0][COST_W-1:0]     s4;
    logic [NUM_PART-1:0][COST_W-1:0] part_cost;
    logic [NUM_PART-1:0][COST_W-1:0] bank_cost;
    logic [NUM_PART-1:0][MV_W-1:0]   bank_mvx;
    logic [NUM_PART-1:0][MV_W-1:0]   bank_mvy;

    for (genvar br = 0; br < G; br++) begin : g_brow
        for (genvar bc = 0; bc < G; bc++) begin : g_bcol
            logic [BLK_B-1:0] cur_blk;
            logic [BLK_B-1:0] ref_blk;
            for (genvar y = 0; y < BLK; y++) begin : g_y
                for (genvar x = 0; x < BLK; x++) begin : g_x
                    localparam int SRC = ((br*BLK + y) * MB_DIM + bc*BLK + x) * PIX_W;
                    assign cur_blk[(y*BLK+x)*PIX_W +: PIX_W] = cur_pix[SRC +: PIX_W];
                    assign ref_blk[(y*BLK+x)*PIX_W +: PIX_W] = ref_pix[SRC +: PIX_W];
                end
            end
            vbs_blk_sad #(
                .PIX_W  (PIX_W),
                .TRUNC_W(TRUNC_W),
                .BLK    (BLK),
                .COST_W (COST_W),
                .PARITY ((br*BLK + bc*BLK) % 2)
            ) u_blk (
                .cur_blk(cur_blk),
                .ref_blk(ref_blk),
                .sad    (s4[br*G+bc])
            );
        end
    end

    vbs_merge #(.COST_W(COST_W)) u_merge (
        .s4  (s4),
        .part(part_cost)
    );

    vbs_best_bank #(
        .NP    (NUM_PART),
        .COST_W(COST_W),
        .MV_W  (MV_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .mb_start  (mb_start),
        .cand_valid(cand_valid),
        .cand_cost (part_cost),
        .cand_mv_x (cand_mv_x),
        .cand_mv_y (cand_mv_y),
        .best_cost (bank_cost),
        .best_mv_x (bank_mvx),
        .best_mv_y (bank_mvy)
    );

    assign best_cost = bank_cost;
    assign best_mv_x = bank_mvx;
    assign best_mv_y = bank_mvy;
endmodule

// File: rtl/vbs_sad_tree_chk.sv
module vbs_sad_tree_chk #(
    parameter int NP      = 41,
    parameter int COST_W  = 12,
    parameter int MV_W    = 8,
    parameter int MAX_SUM = 3968
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       mb_start,
    input logic                       cand_valid,
    input logic [MV_W-1:0]            cand_mv_x,
    input logic [MV_W-1:0]            cand_mv_y,
    input logic [NP-1:0][COST_W-1:0]  best_cost,
    input logic [NP-1:0][MV_W-1:0]    best_mv_x,
    input logic [NP-1:0][MV_W-1:0]    best_mv_y
);
    localparam logic [COST_W-1:0] CLEARED = '1;

    assert_clear_on_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_start && !cand_valid) |=> (best_cost == {NP{CLEARED}}) &&
                                      (best_mv_x == '0) && (best_mv_y == '0));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mb_start && !cand_valid) |=> $stable(best_cost) && $stable(best_mv_x) &&
                                       $stable(best_mv_y));

    assert_cost_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (best_cost[NP-1] != CLEARED) |-> (best_cost[NP-1] <= COST_W'(MAX_SUM)));

    for (genvar i = 0; i < NP; i++) begin : g_slot
        assert_start_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (mb_start && cand_valid) |=> (best_mv_x[i] == $past(cand_mv_x)) &&
                                         (best_mv_y[i] == $past(cand_mv_y)) &&
                                         (best_cost[i] != CLEARED));

        assert_never_worse_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !mb_start |=> (best_cost[i] <= $past(best_cost[i])));

        assert_vector_needs_gain_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !mb_start |=> ($stable(best_mv_x[i]) && $stable(best_mv_y[i])) ||
                          (best_cost[i] < $past(best_cost[i])));
    end
endmodule

bind vbs_sad_tree vbs_sad_tree_chk #(
    .NP     (vbs_pkg::NUM_PART),
    .COST_W (COST_W),
    .MV_W   (MV_W),
    .MAX_SUM(((MB_DIM * MB_DIM) / 2) * ((2 ** TRUNC_W) - 1))
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mb_start  (mb_start),
    .cand_valid(cand_valid),
    .cand_mv_x (cand_mv_x),
    .cand_mv_y (cand_mv_y),
    .best_cost (best_cost),
    .best_mv_x (best_mv_x),
    .best_mv_y (best_mv_y)
);

// File: tb/tb_vbs_sad_tree.sv
`timescale 1ns/1ps
module tb_vbs_sad_tree;
    localparam int NP   = 41;
    localparam int CW   = 12;
    localparam int MVW  = 8;
    localparam int NPIX = 256;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 mb_start = 1'b0;
    logic                 cand_valid = 1'b0;
    logic [NPIX*8-1:0]    cur_pix = '0;
    logic [NPIX*8-1:0]    ref_pix = '0;
    logic [MVW-1:0]       cand_mv_x = '0;
    logic [MVW-1:0]       cand_mv_y = '0;
    logic [NP*CW-1:0]     best_cost;
    logic [NP*MVW-1:0]    best_mv_x;
    logic [NP*MVW-1:0]    best_mv_y;

    vbs_sad_tree dut (
        .clk(clk), .rst_n(rst_n), .mb_start(mb_start), .cand_valid(cand_valid),
        .cur_pix(cur_pix), .ref_pix(ref_pix), .cand_mv_x(cand_mv_x),
        .cand_mv_y(cand_mv_y), .best_cost(best_cost), .best_mv_x(best_mv_x),
        .best_mv_y(best_mv_y)
    );

    always #10 clk = ~clk;

    int cur[NPIX];
    int rfp[NPIX];
    int m_cost[NP];
    int m_mx[NP];
    int m_my[NP];
    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    function automatic string slot_tag(input int i);
        if (i < 16) return "R3";
        if (i < 32) return "R4";
        return "R5";
    endfunction

    function automatic int part_sad(input int i);
        int x0, y0, w, h, j, s, a, b;
        if (i < 16)      begin w = 4;  h = 4;  y0 = (i/4)*4;  x0 = (i%4)*4; end
        else if (i < 24) begin j = i-16; w = 8;  h = 4;  y0 = (j/2)*4; x0 = (j%2)*8; end
        else if (i < 32) begin j = i-24; w = 4;  h = 8;  y0 = (j/4)*8; x0 = (j%4)*4; end
        else if (i < 36) begin j = i-32; w = 8;  h = 8;  y0 = (j/2)*8; x0 = (j%2)*8; end
        else if (i < 38) begin j = i-36; w = 16; h = 8;  y0 = j*8;     x0 = 0;       end
        else if (i < 40) begin j = i-38; w = 8;  h = 16; y0 = 0;       x0 = j*8;     end
        else             begin w = 16; h = 16; y0 = 0; x0 = 0; end
        s = 0;
        for (int y = y0; y < y0 + h; y++) begin
            for (int x = x0; x < x0 + w; x++) begin
                if (((x + y) % 2) == 0) begin
                    a = cur[y*16+x] / 8;
                    b = rfp[y*16+x] / 8;
                    s += (a > b) ? a - b : b - a;
                end
            end
        end
        return s;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < NP; i++) begin
            m_cost[i] = 4095; m_mx[i] = 0; m_my[i] = 0;
        end
    endtask

    task automatic compare(input string ctx);
        int bad;
        int gc, gx, gy;
        bad = 0;
        vectors++;
        for (int i = 0; i < NP; i++) begin
            gc = int'(best_cost[i*CW +: CW]);
            gx = int'(best_mv_x[i*MVW +: MVW]);
            gy = int'(best_mv_y[i*MVW +: MVW]);
            if (gc != m_cost[i] || gx != m_mx[i] || gy != m_my[i]) begin
                bad++;
                if (bad <= 3)
                    $display("FAIL %s/%s slot %0d: got cost %0d mv (%0d,%0d) expected cost %0d mv (%0d,%0d)",
                             ctx, slot_tag(i), i, gc, gx, gy, m_cost[i], m_mx[i], m_my[i]);
            end
        end
        if (bad != 0) miscompares++;
    endtask

    task automatic pack_pixels();
        for (int p = 0; p < NPIX; p++) begin
            cur_pix[p*8 +: 8] = 8'(cur[p]);
            ref_pix[p*8 +: 8] = 8'(rfp[p]);
        end
    endtask

    // Called at a falling edge: drive inputs, advance the model, check after next rise
    task automatic step(input bit v, input bit s, input int mx, input int my, input string ctx);
        int c;
        pack_pixels();
        cand_valid = v;
        mb_start   = s;
        cand_mv_x  = 8'(mx);
        cand_mv_y  = 8'(my);
        if (s) model_clear();
        if (v) begin
            for (int i = 0; i < NP; i++) begin
                c = part_sad(i);
                if (c < m_cost[i]) begin
                    m_cost[i] = c; m_mx[i] = mx & 255; m_my[i] = my & 255;
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        compare(ctx);
    endtask

    task automatic random_pixels();
        for (int p = 0; p < NPIX; p++) begin
            cur[p] = $urandom_range(255);
            rfp[p] = $urandom_range(255);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog: got no completion, expected completion within limit");
            miscompares++;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        model_clear();
        random_pixels();
        pack_pixels();
        cand_valid = 1'b1;
        // R1: reset holds cleared state even with a valid candidate present
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            compare("R1 reset");
        end
        rst_n = 1'b1;
        cand_valid = 1'b0;

        // R8: start without a candidate clears
        step(1'b1, 1'b0, 12, 34, "R6 first candidate");
        step(1'b0, 1'b1, 0, 0, "R8 clear");

        // R2: differences only in low bits or on odd-parity positions
        random_pixels();
        for (int p = 0; p < NPIX; p++) begin
            if ((((p / 16) + (p % 16)) % 2) == 0)
                rfp[p] = (cur[p] & 248) | $urandom_range(7);
        end
        step(1'b1, 1'b1, 1, 2, "R2 zero cost / R8 start with candidate");

        // R6: equal cost keeps the earlier vector
        step(1'b1, 1'b0, 5, 5, "R6 tie");
        random_pixels();
        step(1'b1, 1'b0, 9, 9, "R6 worse candidate");

        // R9: idle cycles with moving inputs
        for (int k = 0; k < 4; k++) begin
            random_pixels();
            step(1'b0, 1'b0, k, k, "R9 idle");
        end

        // R10: largest difference
        for (int p = 0; p < NPIX; p++) begin cur[p] = 255; rfp[p] = 0; end
        step(1'b1, 1'b1, 127, 128, "R10 max cost");
        step(1'b0, 1'b0, 0, 0, "R10 hold");

        // R7 and R3..R5: random searches, slots update independently
        for (int mb = 0; mb < 6; mb++) begin
            random_pixels();
            step($urandom_range(1) == 1, 1'b1, $urandom_range(255), $urandom_range(255), "R8 search start");
            for (int k = 0; k < 40; k++) begin
                random_pixels();
                // bias part of the block towards a close match so slots diverge
                if ($urandom_range(3) == 0) begin
                    for (int p = 0; p < NPIX; p++)
                        if ((p % 16) < 8) rfp[p] = cur[p];
                end
                step($urandom_range(3) != 0, 1'b0, $urandom_range(255),
                     $urandom_range(255), "R7 search");
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule